// File: doc/BRIEF.md
# SONET/SDH Transmit Overhead Byte Inserter

This block sits on the transmit byte stream of a 155 Mbit/s SONET/SDH frame and overwrites selected transport overhead bytes. An external frame-position counter supplies the row and column of every byte together with a byte strobe. The byte arriving at row 0, column 0 marks the start of a frame. The block passes each byte through with one cycle of latency. In the overhead slots it replaces the byte with a value from one of four sources: a host-programmed value, a byte from a side-band overhead access channel, a value computed in the block, or a fixed default.

The host controls each slot on its own. The trace byte steps through a 16-byte host-programmed message, one byte per frame. The APS bits of K1/K2 are controlled apart from the low three bits of K2. The growth bytes Z0-2 and Z0-3 share one control. S1 and F1 can each come from the host, from the access channel or from a default. M1 reports the B2 error count of the frame, capped at 24, unless this report is inhibited. A line AIS command forces every byte below the section overhead rows to all ones.

All host controls, host values and the B2 count are captured together on the first byte of each frame. A host write made partway through a frame therefore takes effect only at the next frame boundary.

Top module: `sonet_toh_inserter`

## Requirements
- R1: While reset is asserted, and until the first strobed byte after reset, `dout` is 0x00 and `dout_vld` is 0. With every control at 0 the first frame shows the default bytes: trace 0x01, Z0-2 0x02, Z0-3 0x03, K1 0x00, K2 0x00, S1 0x0F and F1 0x00.
- R2: `dout_vld` is high exactly one cycle after each cycle with `byte_en` high. `dout` then holds the byte strobed in that earlier cycle. Bytes that are not overhead slots are passed through unchanged, except where R4 applies.
- R3: The M1 byte (row 8, column 5, counted from 0) equals the B2 error count captured for the frame, capped at 24, while `rei_inhibit` is 0. While `rei_inhibit` is 1, M1 is 0x00.
- R4: While `line_ais` is 1, every byte in rows 3 to 8, overhead and payload alike, is 0xFF. Rows 0 to 2 keep their normal content.
- R5: K1 (row 4, column 3) and K2[7:3] (row 4, column 6) take `aps_value[12:5]` and `aps_value[4:0]` while `aps_sel` is 1. While `aps_sel` is 0 they take their defaults (0x00 and 5'b00000).
- R6: K2[2:0] takes `k2_low_value` while `k2_low_sel` is 1, and 3'b000 otherwise, independently of `aps_sel`.
- R7: S1 (row 8, column 0) and F1 (row 1, column 6) each take the host byte while their select is 1. With the select at 0 they take `oac_byte` if `oac_vld` is high in that byte's cycle, and otherwise their default (S1 0x0F, F1 0x00).
- R8: While `z0_sel` is 1, Z0-2 (row 0, column 7) and Z0-3 (row 0, column 8) take `z0_2_value` and `z0_3_value`. Otherwise they take 0x02 and 0x03.
- R9: While `trace_sel` is 1, the trace byte (row 0, column 6) of frame k after reset (k from 0) is byte k mod 16 of `trace_msg`, where byte i is bits [8i+7:8i]. Otherwise it is 0x01.
- R10: Controls, host values, the trace byte and the B2 count are sampled only on the strobed byte at row 0, column 0. Changes on those inputs later in the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_en | input | 1 | Byte strobe from the frame-position counter |
| row | input | 4 | Row of the strobed byte, 0 to 8 |
| col | input | 9 | Column of the strobed byte, 0 to 269 |
| din | input | 8 | Incoming byte |
| oac_vld | input | 1 | Access channel is supplying a byte this cycle |
| oac_byte | input | 8 | Access channel byte |
| b2_errs | input | 5 | B2 error count to report in this frame |
| rei_inhibit | input | 1 | Stop hardware M1 insertion |
| line_ais | input | 1 | Force line AIS |
| aps_sel | input | 1 | Insert host K1 and K2[7:3] |
| k2_low_sel | input | 1 | Insert host K2[2:0] |
| s1_sel | input | 1 | Insert host S1 |
| f1_sel | input | 1 | Insert host F1 |
| z0_sel | input | 1 | Insert host Z0-2 and Z0-3 |
| trace_sel | input | 1 | Insert host trace message |
| aps_value | input | 13 | K1 in [12:5], K2[7:3] in [4:0] |
| k2_low_value | input | 3 | Host K2[2:0] |
| s1_value | input | 8 | Host S1 |
| f1_value | input | 8 | Host F1 |
| z0_2_value | input | 8 | Host Z0-2 |
| z0_3_value | input | 8 | Host Z0-3 |
| trace_msg | input | 128 | 16-byte trace message |
| dout | output | 8 | Outgoing byte |
| dout_vld | output | 1 | Outgoing byte valid |

## Verification
Whole frames are streamed with a distinct pass-through pattern in every byte. Each frame carries one control pattern, so that every slot is seen in its default, host and, for S1/F1, access-channel states. The M1 counts 0, 7, 24, 25 and 30 separate passing the count through from capping it. An AIS frame separates rows 0 to 2, which must be kept, from rows 3 to 8, which must be forced. Eighteen trace frames cross the 15-to-0 wrap. In every frame the live controls are inverted from row 3 on, and the strobe-off gap between rows presents row 0/column 0, which separates sampling at the frame start from later or unstrobed sampling.

// File: rtl/toh_pkg.sv
package toh_pkg;

  typedef enum logic [3:0] {
    SL_NONE, SL_J0, SL_Z02, SL_Z03, SL_F1, SL_K1, SL_K2, SL_S1, SL_M1
  } slot_e;

  // Slot positions, 0-based row/column within an STS-3 frame.
  localparam int J0_ROW  = 0;  localparam int J0_COL  = 6;
  localparam int Z02_ROW = 0;  localparam int Z02_COL = 7;
  localparam int Z03_ROW = 0;  localparam int Z03_COL = 8;
  localparam int F1_ROW  = 1;  localparam int F1_COL  = 6;
  localparam int K1_ROW  = 4;  localparam int K1_COL  = 3;
  localparam int K2_ROW  = 4;  localparam int K2_COL  = 6;
  localparam int S1_ROW  = 8;  localparam int S1_COL  = 0;
  localparam int M1_ROW  = 8;  localparam int M1_COL  = 5;

  typedef struct packed {
    logic       rei_inh;
    logic       ais;
    logic       aps;
    logic       k2lo;
    logic       s1;
    logic       f1;
    logic       z0;
    logic       j0;
    logic [12:0] aps_val;
    logic [2:0]  k2lo_val;
    logic [7:0]  s1_val;
    logic [7:0]  f1_val;
    logic [7:0]  z02_val;
    logic [7:0]  z03_val;
  } host_ctl_t;

  typedef struct packed {
    host_ctl_t  ctl;
    logic [7:0] j0_byte;
    logic [7:0] m1_val;
  } frame_cfg_t;

endpackage

// File: rtl/toh_pos_decode.sv
module toh_pos_decode
  import toh_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 9,
  parameter int LINE_ROW = 3
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output slot_e            slot_o,
  output logic             line_o
);

  function automatic logic at(input int r, input int c, input int sr, input int sc);
    return (r == sr) && (c == sc);
  endfunction

  int r_i;
  int c_i;

  always_comb begin
    r_i    = int'(row_i);
    c_i    = int'(col_i);
    line_o = (r_i >= LINE_ROW);
    slot_o = SL_NONE;
    if      (at(r_i, c_i, J0_ROW,  J0_COL))  slot_o = SL_J0;
    else if (at(r_i, c_i, Z02_ROW, Z02_COL)) slot_o = SL_Z02;
    else if (at(r_i, c_i, Z03_ROW, Z03_COL)) slot_o = SL_Z03;
    else if (at(r_i, c_i, F1_ROW,  F1_COL))  slot_o = SL_F1;
    else if (at(r_i, c_i, K1_ROW,  K1_COL))  slot_o = SL_K1;
    else if (at(r_i, c_i, K2_ROW,  K2_COL))  slot_o = SL_K2;
    else if (at(r_i, c_i, S1_ROW,  S1_COL))  slot_o = SL_S1;
    else if (at(r_i, c_i, M1_ROW,  M1_COL))  slot_o = SL_M1;
  end

endmodule

// File: rtl/toh_frame_shadow.sv
module toh_frame_shadow
  import toh_pkg::*;
#(
  parameter int B2_W      = 5,
  parameter int TRACE_LEN = 16,
  parameter int M1_CAP    = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sof_i,
  input  host_ctl_t              ctl_i,
  input  logic [B2_W-1:0]        b2_i,
  input  logic [TRACE_LEN*8-1:0] trace_i,
  output frame_cfg_t             cfg_o
);

  localparam int IDX_W = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TRACE_LEN - 1);

  logic [7:0]       trace_b [TRACE_LEN];
  logic [IDX_W-1:0] idx_q, idx_d;
  frame_cfg_t       cfg_q, cfg_d;
  logic [7:0]       m1_sat;

  for (genvar g = 0; g < TRACE_LEN; g++) begin : g_trace
    assign trace_b[g] = trace_i[8*g +: 8];
  end

  always_comb begin
    if (32'(b2_i) > M1_CAP) m1_sat = 8'(M1_CAP);
    else                    m1_sat = 8'(b2_i);
    idx_d         = (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
    cfg_d.ctl     = ctl_i;
    cfg_d.j0_byte = trace_b[idx_d];
    cfg_d.m1_val  = m1_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_LAST;
      cfg_q <= '0;
    end else if (sof_i) begin
      idx_q <= idx_d;
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  assert_trace_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && idx_q == IDX_LAST) |=> (idx_q == '0));

  assert_trace_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && idx_q != IDX_LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(cfg_q));

  assert_m1_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.m1_val <= 8'(M1_CAP));

endmodule

// File: rtl/toh_byte_select.sv
module toh_byte_select
  import toh_pkg::*;
#(
  parameter logic [7:0] DEF_J0  = 8'h01,
  parameter logic [7:0] DEF_Z02 = 8'h02,
  parameter logic [7:0] DEF_Z03 = 8'h03,
  parameter logic [7:0] DEF_K1  = 8'h00,
  parameter logic [7:0] DEF_K2  = 8'h00,
  parameter logic [7:0] DEF_S1  = 8'h0F,
  parameter logic [7:0] DEF_F1  = 8'h00,
  parameter logic [7:0] DEF_M1  = 8'h00
) (
  input  slot_e      slot_i,
  input  logic       line_i,
  input  logic [7:0] din_i,
  input  logic       oac_vld_i,
  input  logic [7:0] oac_byte_i,
  input  frame_cfg_t cfg_i,
  output logic [7:0] byte_o
);

  logic [7:0] k1_b, k2_b, s1_b, f1_b;

  always_comb begin
    k1_b = cfg_i.ctl.aps ? cfg_i.ctl.aps_val[12:5] : DEF_K1;
    k2_b = { (cfg_i.ctl.aps  ? cfg_i.ctl.aps_val[4:0] : DEF_K2[7:3]),
             (cfg_i.ctl.k2lo ? cfg_i.ctl.k2lo_val     : DEF_K2[2:0]) };
    s1_b = cfg_i.ctl.s1 ? cfg_i.ctl.s1_val : (oac_vld_i ? oac_byte_i : DEF_S1);
    f1_b = cfg_i.ctl.f1 ? cfg_i.ctl.f1_val : (oac_vld_i ? oac_byte_i : DEF_F1);

    byte_o = din_i;
    unique case (slot_i)
      SL_J0:   byte_o = cfg_i.ctl.j0 ? cfg_i.j0_byte     : DEF_J0;
      SL_Z02:  byte_o = cfg_i.ctl.z0 ? cfg_i.ctl.z02_val : DEF_Z02;
      SL_Z03:  byte_o = cfg_i.ctl.z0 ? cfg_i.ctl.z03_val : DEF_Z03;
      SL_F1:   byte_o = f1_b;
      SL_K1:   byte_o = k1_b;
      SL_K2:   byte_o = k2_b;
      SL_S1:   byte_o = s1_b;
      SL_M1:   byte_o = cfg_i.ctl.rei_inh ? DEF_M1 : cfg_i.m1_val;
      default: byte_o = din_i;
    endcase

    if (cfg_i.ctl.ais && line_i) byte_o = 8'hFF;
  end

endmodule

// File: rtl/sonet_toh_inserter.sv
module sonet_toh_inserter
  import toh_pkg::*;
#(
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int LINE_ROW  = 3,
  parameter int B2_W      = 5,
  parameter int TRACE_LEN = 16,
  parameter int M1_CAP    = 24,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_en,
  input  logic [ROW_W-1:0]       row,
  input  logic [COL_W-1:0]       col,
  input  logic [7:0]             din,
  input  logic                   oac_vld,
  input  logic [7:0]             oac_byte,
  input  logic [B2_W-1:0]        b2_errs,
  input  logic                   rei_inhibit,
  input  logic                   line_ais,
  input  logic                   aps_sel,
  input  logic                   k2_low_sel,
  input  logic                   s1_sel,
  input  logic                   f1_sel,
  input  logic                   z0_sel,
  input  logic                   trace_sel,
  input  logic [12:0]            aps_value,
  input  logic [2:0]             k2_low_value,
  input  logic [7:0]             s1_value,
  input  logic [7:0]             f1_value,
  input  logic [7:0]             z0_2_value,
  input  logic [7:0]             z0_3_value,
  input  logic [TRACE_LEN*8-1:0] trace_msg,
  output logic [7:0]             dout,
  output logic                   dout_vld
);

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  host_ctl_t  live_ctl;
  frame_cfg_t cfg;
  slot_e      slot;
  logic       line_rgn;
  logic       sof;
  logic [7:0] sel_byte;
  logic [7:0] dout_q;
  logic       vld_q;

  always_comb begin
    live_ctl.rei_inh  = rei_inhibit;
    live_ctl.ais      = line_ais;
    live_ctl.aps      = aps_sel;
    live_ctl.k2lo     = k2_low_sel;
    live_ctl.s1       = s1_sel;
    live_ctl.f1       = f1_sel;
    live_ctl.z0       = z0_sel;
    live_ctl.j0       = trace_sel;
    live_ctl.aps_val  = aps_value;
    live_ctl.k2lo_val = k2_low_value;
    live_ctl.s1_val   = s1_value;
    live_ctl.f1_val   = f1_value;
    live_ctl.z02_val  = z0_2_value;
    live_ctl.z03_val  = z0_3_value;
    sof = byte_en && (row == '0) && (col == '0);
  end

  toh_pos_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .LINE_ROW(LINE_ROW)) u_decode (
    .row_i (row),
    .col_i (col),
    .slot_o(slot),
    .line_o(line_rgn)
  );

  toh_frame_shadow #(.B2_W(B2_W), .TRACE_LEN(TRACE_LEN), .M1_CAP(M1_CAP)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .sof_i  (sof),
    .ctl_i  (live_ctl),
    .b2_i   (b2_errs),
    .trace_i(trace_msg),
    .cfg_o  (cfg)
  );

  toh_byte_select u_select (
    .slot_i    (slot),
    .line_i    (line_rgn),
    .din_i     (din),
    .oac_vld_i (oac_vld),
    .oac_byte_i(oac_byte),
    .cfg_i     (cfg),
    .byte_o    (sel_byte)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= byte_en;
      if (byte_en) dout_q <= sel_byte;
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q;

  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    byte_en |=> dout_vld);

  assert_no_stray_vld_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !byte_en |=> !dout_vld);

  assert_soh_kept_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_en && !line_rgn && slot == SL_NONE) |=> (dout == $past(din)));

  assert_ais_ones_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_en && cfg.ctl.ais && line_rgn) |=> (dout == 8'hFF));

  assert_m1_bound_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_en && slot == SL_M1 && !cfg.ctl.ais) |=> (dout <= 8'(M1_CAP)));

endmodule

// File: tb/sonet_toh_inserter_tb_top.sv
module sonet_toh_inserter_tb_top;

  typedef struct packed {
    logic        rei, ais, aps, k2lo, s1, f1, z0, j0;
    logic [12:0] apsv;
    logic [2:0]  k2v;
    logic [7:0]  s1v, f1v, z2v, z3v;
    logic [4:0]  b2;
  } tcfg_t;

  localparam int NFRAMES = 28;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         byte_en;
  logic [3:0]   row;
  logic [8:0]   col;
  logic [7:0]   din;
  logic         oac_vld;
  logic [7:0]   oac_byte;
  logic [4:0]   b2_errs;
  logic         rei_inhibit, line_ais, aps_sel, k2_low_sel, s1_sel, f1_sel, z0_sel, trace_sel;
  logic [12:0]  aps_value;
  logic [2:0]   k2_low_value;
  logic [7:0]   s1_value, f1_value, z0_2_value, z0_3_value;
  logic [127:0] trace_msg;
  logic [7:0]   dout;
  logic         dout_vld;

  logic [127:0] trace_base;
  logic [7:0]   exp_q[$];
  string        tag_q[$];
  int total = 0;
  int bad   = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sonet_toh_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .row(row), .col(col), .din(din),
    .oac_vld(oac_vld), .oac_byte(oac_byte), .b2_errs(b2_errs),
    .rei_inhibit(rei_inhibit), .line_ais(line_ais), .aps_sel(aps_sel),
    .k2_low_sel(k2_low_sel), .s1_sel(s1_sel), .f1_sel(f1_sel), .z0_sel(z0_sel),
    .trace_sel(trace_sel), .aps_value(aps_value), .k2_low_value(k2_low_value),
    .s1_value(s1_value), .f1_value(f1_value), .z0_2_value(z0_2_value),
    .z0_3_value(z0_3_value), .trace_msg(trace_msg), .dout(dout), .dout_vld(dout_vld)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic put_cfg(input tcfg_t c, input logic [127:0] tr);
    rei_inhibit = c.rei; line_ais = c.ais; aps_sel = c.aps; k2_low_sel = c.k2lo;
    s1_sel = c.s1; f1_sel = c.f1; z0_sel = c.z0; trace_sel = c.j0;
    aps_value = c.apsv; k2_low_value = c.k2v; s1_value = c.s1v; f1_value = c.f1v;
    z0_2_value = c.z2v; z0_3_value = c.z3v; b2_errs = c.b2; trace_msg = tr;
  endtask

  function automatic tcfg_t build_cfg(input int k);
    tcfg_t c = '0;
    case (k)
      1: c.b2 = 5'd7;
      2: c.b2 = 5'd30;
      3: begin c.rei = 1'b1; c.b2 = 5'd9; end
      4: begin c.ais = 1'b1; c.b2 = 5'd3; end
      5: begin c.aps = 1'b1; c.apsv = 13'h15A5; end
      6: begin c.k2lo = 1'b1; c.k2v = 3'b101; end
      7: begin c.aps = 1'b1; c.k2lo = 1'b1; c.apsv = 13'h0F3E; c.k2v = 3'b010;
               c.s1 = 1'b1; c.f1 = 1'b1; c.s1v = 8'h3C; c.f1v = 8'hC3; end
      9: begin c.z0 = 1'b1; c.z2v = 8'h9A; c.z3v = 8'hB7; c.b2 = 5'd24; end
      default: ;
    endcase
    if (k >= 10) begin c.j0 = 1'b1; c.b2 = (k == 20) ? 5'd25 : 5'(k); end
    return c;
  endfunction

  function automatic tcfg_t perturb(input tcfg_t c);
    tcfg_t p = ~c;
    p.b2 = 5'd31 - c.b2;
    return p;
  endfunction

  function automatic void model(input int r, input int c, input logic [7:0] d,
                                input logic ov, input logic [7:0] ob, input tcfg_t f,
                                input int fidx, output logic [7:0] e, output string tag);
    e = d; tag = "R2";
    if (r == 0 && c == 6) begin
      e = f.j0 ? trace_base[8*(fidx % 16) +: 8] : 8'h01; tag = "R9";
    end else if (r == 0 && c == 7) begin
      e = f.z0 ? f.z2v : 8'h02; tag = "R8";
    end else if (r == 0 && c == 8) begin
      e = f.z0 ? f.z3v : 8'h03; tag = "R8";
    end else if (r == 1 && c == 6) begin
      e = f.f1 ? f.f1v : (ov ? ob : 8'h00); tag = "R7";
    end else if (r == 4 && c == 3) begin
      e = f.aps ? f.apsv[12:5] : 8'h00; tag = "R5/R10";
    end else if (r == 4 && c == 6) begin
      e = {(f.aps ? f.apsv[4:0] : 5'b0), (f.k2lo ? f.k2v : 3'b0)}; tag = "R6/R5/R10";
    end else if (r == 8 && c == 0) begin
      e = f.s1 ? f.s1v : (ov ? ob : 8'h0F); tag = "R7/R10";
    end else if (r == 8 && c == 5) begin
      e = f.rei ? 8'h00 : ((f.b2 > 5'd24) ? 8'd24 : {3'b0, f.b2}); tag = "R3/R10";
    end
    if (fidx == 0 && r == 0 && c >= 6) tag = {tag, "/R1"};
    if (f.ais) begin
      tag = {tag, "/R4"};
      if (r >= 3) e = 8'hFF;
    end
  endfunction

  // Monitor: pops expected bytes as the design produces them.
  always @(negedge clk) begin
    if (rst_n && dout_vld) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: output valid with no byte pending, got %02h expected none", dout);
      end else begin
        popped++;
        check(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tcfg_t fc;
    logic [7:0] e;
    string tag;
    for (int i = 0; i < 16; i++) trace_base[8*i +: 8] = 8'h50 + 8'(i * 11);
    rst_n = 1'b0; byte_en = 1'b0; row = '0; col = '0; din = '0;
    oac_vld = 1'b0; oac_byte = '0;
    put_cfg('0, trace_base);
    repeat (4) @(negedge clk);
    check("R1 reset dout", dout, 8'h00);
    check("R1 reset vld", {7'b0, dout_vld}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle dout", dout, 8'h00);
    check("R1 idle vld", {7'b0, dout_vld}, 8'h00);

    for (int k = 0; k < NFRAMES; k++) begin
      fc = build_cfg(k);
      put_cfg(fc, trace_base);
      for (int r = 0; r < 9; r++) begin
        if (r == 3) put_cfg(perturb(fc), ~trace_base);
        for (int c = 0; c < 270; c++) begin
          @(negedge clk);
          byte_en  = 1'b1;
          row      = 4'(r);
          col      = 9'(c);
          din      = 8'(r * 31 + c * 7 + k);
          oac_vld  = (k == 7 || k == 8 || (k % 3) == 1);
          oac_byte = 8'hE0 ^ 8'(k);
          model(r, c, din, oac_vld, oac_byte, fc, k, e, tag);
          exp_q.push_back(e);
          tag_q.push_back(tag);
          pushed++;
        end
        // Unstrobed gap presenting row 0 / column 0: must not start a frame (R10).
        @(negedge clk);
        byte_en = 1'b0; row = '0; col = '0; din = 8'h5A;
      end
    end
    repeat (6) @(negedge clk);
    check("R2 bytes out vs in", 8'(popped - pushed), 8'h00);
    check("R2 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule